// File: doc/BRIEF.md
# Programmable Raster Timing Generator for Parallel RGB Panels

This block generates the raster timing for a parallel RGB display: horizontal sync, vertical sync, a data-enable strobe that marks visible pixels, and a one-cycle pixel-clock-enable that paces everything at the pixel rate. Every timing length is supplied on input fields held by the surrounding register file, so one instance drives panels of any geometry within the counter widths.

Each field holds its length minus one. The horizontal line runs through four phases in a fixed order: sync, back porch, active, front porch. The vertical frame runs through the same four phases, counted in whole lines, and advances one line when a horizontal line finishes. The pixel rate comes from the input clock. When the divide-select bit is set, the rate is the input clock divided by the divider field plus one. When the bit is clear, the rate is the input clock itself. A frame interrupt flag is set when vertical sync begins, provided both the master and the frame interrupt enables are set. The flag stays set until a 1 is written to the acknowledge input.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted and scan_en is low, de, pix_ce and irq_pending are 0 and both sync outputs sit at their inactive level. The counters restart in the horizontal sync phase of the vertical sync phase.
- R2: With scan_en high and div_sel low, pix_ce is 1 on every clock cycle.
- R3: With scan_en high and div_sel high, pix_ce is 1 on one cycle in every div_m1+1 cycles. div_m1 = 0 gives a pulse on every cycle.
- R4: The horizontal phases follow the order sync, back porch, active, front porch. Each phase lasts its field plus one pixel-enable pulses.
- R5: The vertical phases follow the same order. Each phase lasts its field plus one lines, and a line ends with the last front-porch pixel of the horizontal sequence.
- R6: de is 1 only when the horizontal and the vertical sequences are both in their active phase.
- R7: A sync output is driven high during its sync phase when its polarity bit is 1, and driven low during its sync phase when the bit is 0. Outside the sync phase it takes the opposite level.
- R8: irq_pending becomes 1 on the cycle in which vertical sync begins after a full frame, but only if irq_master_en and irq_frame_en are both 1. If either enable is 0, the flag is not set.
- R9: A 1 on irq_ack clears irq_pending on the next cycle. If a new frame event occurs in the same cycle, the set wins.
- R10: While scan_en is low, pix_ce and de are 0, both syncs are inactive and the counters are held at their start. Raising scan_en again begins a frame with horizontal and vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | Runs the counters; low halts and idles the outputs |
| div_sel | input | 1 | 1 selects division by div_m1+1, 0 selects a 1:1 pixel rate |
| div_m1 | input | DIV_W | Divide ratio minus one |
| h_sync_m1 | input | H_W | Horizontal sync width in pixels, minus one |
| h_back_m1 | input | H_W | Horizontal back porch in pixels, minus one |
| h_act_m1 | input | H_W | Active pixels per line, minus one |
| h_front_m1 | input | H_W | Horizontal front porch in pixels, minus one |
| v_sync_m1 | input | V_W | Vertical sync width in lines, minus one |
| v_back_m1 | input | V_W | Vertical back porch in lines, minus one |
| v_act_m1 | input | V_W | Active lines, minus one |
| v_front_m1 | input | V_W | Vertical front porch in lines, minus one |
| hs_pol | input | 1 | 1 = horizontal sync active high |
| vs_pol | input | 1 | 1 = vertical sync active high |
| irq_master_en | input | 1 | Global interrupt enable |
| irq_frame_en | input | 1 | Frame interrupt enable |
| irq_ack | input | 1 | Write-1-to-clear strobe for the pending flag |
| pix_ce | output | 1 | Pixel-rate clock enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable for visible pixels |
| irq_pending | output | 1 | Frame interrupt pending flag |

## Verification
A wrong divider count appears on pix_ce within one divide period, and every later phase boundary then drifts. A horizontal phase or count error moves the hsync and de edges within one line. A vertical error shows on vsync and de no later than the next line boundary, and on irq_pending at the next frame start. A behavioural model in the bench predicts all five outputs, and the outputs are compared with it on every cycle, so any such fault is reported within the cycle it first reaches a port.

// File: rtl/lcd_tg_pkg.sv
// Shared types for the raster timing generator.
// Assumes phases are visited in declaration order and wrap from the last to the first.
package lcd_tg_pkg;
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } tg_phase_e;
endpackage

// File: rtl/lcd_tg_clkdiv.sv
// Pixel-rate enable generator.
// Issues one pix_ce pulse every div_m1+1 input cycles when div_sel is set,
// or on every cycle when div_sel is clear. Assumes div_m1 may change at any
// time; a count above the new limit wraps at once.
module lcd_tg_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             div_sel,
    input  logic [DIV_W-1:0] div_m1,
    output logic             pix_ce
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_lim;

    assign at_lim = (cnt_q >= div_m1);
    assign pix_ce = run & (~div_sel | at_lim);

    // Divide counter: free-runs while dividing, held at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!run || !div_sel)  cnt_q <= '0;
        else if (at_lim)            cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    // R3
    one_pulse_per_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ce && div_sel && div_m1 != '0) |=> (!pix_ce || !div_sel || div_m1 == '0));

    // R2
    bypass_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !div_sel) |-> pix_ce);
endmodule

// File: rtl/lcd_tg_axis.sv
// One axis of the raster (horizontal or vertical).
// Steps through sync, back porch, active and front porch; each phase lasts its
// length field plus one advance pulses. Assumes adv is a single-cycle strobe.
// 'last' flags the final count of the front porch so that the caller can chain
// the next axis or detect the end of a frame.
module lcd_tg_axis
    import lcd_tg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          adv,
    input  logic [CW-1:0] len_sync,
    input  logic [CW-1:0] len_back,
    input  logic [CW-1:0] len_act,
    input  logic [CW-1:0] len_front,
    output tg_phase_e     phase,
    output logic          last
);
    tg_phase_e     ph_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cur_len;
    logic          ph_done;

    // Length of the phase currently being counted.
    always_comb begin
        unique case (ph_q)
            PH_SYNC:  cur_len = len_sync;
            PH_BACK:  cur_len = len_back;
            PH_ACT:   cur_len = len_act;
            default:  cur_len = len_front;
        endcase
    end

    assign ph_done = (cnt_q >= cur_len);
    assign last    = (ph_q == PH_FRONT) && ph_done;
    assign phase   = ph_q;

    // Phase and count registers: step on adv, restart when halted.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ph_q  <= PH_SYNC;
            cnt_q <= '0;
        end else if (adv) begin
            if (ph_done) begin
                ph_q  <= tg_phase_e'(ph_q + 2'd1);
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !adv) |=> $stable(ph_q));

    // R10
    halt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ph_q == PH_SYNC && cnt_q == '0));
endmodule

// File: rtl/lcd_tg_irq.sv
// Frame interrupt pending flag.
// Set by a frame-start event when both enables are on; cleared by an
// acknowledge strobe (write-1-to-clear). A set in the same cycle wins.
module lcd_tg_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic master_en,
    input  logic frame_en,
    input  logic ack,
    output logic pending
);
    logic set_ev;

    assign set_ev = frame_start & master_en & frame_en;

    // Pending flag register with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      pending <= 1'b0;
        else if (set_ev) pending <= 1'b1;
        else if (ack)    pending <= 1'b0;
    end

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !frame_start) |=> !pending);

    // R8
    gated_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en || !frame_en) |=> !$rose(pending));
endmodule

// File: rtl/lcd_timing_gen.sv
// Raster timing generator top.
// Combines the pixel-rate divider, a horizontal axis stepped by pix_ce, a
// vertical axis stepped at the end of each line, and the frame interrupt flag.
// Assumes all timing and control inputs come from a register file in the same
// clock domain.
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int H_W   = 12,
    parameter int V_W   = 12,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_en,
    input  logic             div_sel,
    input  logic [DIV_W-1:0] div_m1,
    input  logic [H_W-1:0]   h_sync_m1,
    input  logic [H_W-1:0]   h_back_m1,
    input  logic [H_W-1:0]   h_act_m1,
    input  logic [H_W-1:0]   h_front_m1,
    input  logic [V_W-1:0]   v_sync_m1,
    input  logic [V_W-1:0]   v_back_m1,
    input  logic [V_W-1:0]   v_act_m1,
    input  logic [V_W-1:0]   v_front_m1,
    input  logic             hs_pol,
    input  logic             vs_pol,
    input  logic             irq_master_en,
    input  logic             irq_frame_en,
    input  logic             irq_ack,
    output logic             pix_ce,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             irq_pending
);
    tg_phase_e h_ph, v_ph;
    logic      h_last, v_last;
    logic      line_end, frame_end;
    logic      hs_act, vs_act;

    lcd_tg_clkdiv #(.DIV_W(DIV_W)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (scan_en),
        .div_sel (div_sel),
        .div_m1  (div_m1),
        .pix_ce  (pix_ce)
    );

    lcd_tg_axis #(.CW(H_W)) i_h_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (scan_en),
        .adv       (pix_ce),
        .len_sync  (h_sync_m1),
        .len_back  (h_back_m1),
        .len_act   (h_act_m1),
        .len_front (h_front_m1),
        .phase     (h_ph),
        .last      (h_last)
    );

    assign line_end  = pix_ce & h_last;

    lcd_tg_axis #(.CW(V_W)) i_v_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (scan_en),
        .adv       (line_end),
        .len_sync  (v_sync_m1),
        .len_back  (v_back_m1),
        .len_act   (v_act_m1),
        .len_front (v_front_m1),
        .phase     (v_ph),
        .last      (v_last)
    );

    assign frame_end = line_end & v_last;

    lcd_tg_irq i_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_end),
        .master_en   (irq_master_en),
        .frame_en    (irq_frame_en),
        .ack         (irq_ack),
        .pending     (irq_pending)
    );

    // Sync activity and polarity mapping.
    always_comb begin
        hs_act = scan_en && (h_ph == PH_SYNC);
        vs_act = scan_en && (v_ph == PH_SYNC);
        hsync  = hs_pol ? hs_act : ~hs_act;
        vsync  = vs_pol ? vs_act : ~vs_act;
        de     = scan_en && (h_ph == PH_ACT) && (v_ph == PH_ACT);
    end

    // R6
    de_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hs_act && !vs_act && pix_ce == pix_ce));

    // R8
    irq_at_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> (v_ph == PH_SYNC && h_ph == PH_SYNC));

    // R10
    idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_en |-> (!de && !pix_ce && hsync == ~hs_pol && vsync == ~vs_pol));

    // R5
    vert_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en && !line_end) |=> $stable(v_ph));
endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
    localparam int H_W = 12, V_W = 12, DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scan_en = 1'b0, div_sel = 1'b0;
    logic [DIV_W-1:0] div_m1 = '0;
    logic [H_W-1:0] h_sync_m1 = 12'd1, h_back_m1 = 12'd2, h_act_m1 = 12'd3, h_front_m1 = 12'd1;
    logic [V_W-1:0] v_sync_m1 = 12'd0, v_back_m1 = 12'd0, v_act_m1 = 12'd1, v_front_m1 = 12'd0;
    logic hs_pol = 1'b1, vs_pol = 1'b1;
    logic irq_master_en = 1'b0, irq_frame_en = 1'b0, irq_ack = 1'b0;
    logic pix_ce, hsync, vsync, de, irq_pending;

    int compared = 0, mismatched = 0;
    bit started = 0;

    always #10 clk = ~clk;   // 50 MHz

    lcd_timing_gen #(.H_W(H_W), .V_W(V_W), .DIV_W(DIV_W)) i_lcd_timing_gen (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .div_sel(div_sel), .div_m1(div_m1),
        .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1), .h_front_m1(h_front_m1),
        .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1), .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
        .hs_pol(hs_pol), .vs_pol(vs_pol), .irq_master_en(irq_master_en), .irq_frame_en(irq_frame_en),
        .irq_ack(irq_ack), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
        .irq_pending(irq_pending));

    // Behavioural reference state: phase 0..3 = sync, back, active, front.
    int m_div = 0, m_hph = 0, m_hcnt = 0, m_vph = 0, m_vcnt = 0;
    bit m_pend = 0;

    function automatic int hlen(int ph);
        case (ph) 0: return int'(h_sync_m1); 1: return int'(h_back_m1);
                  2: return int'(h_act_m1); default: return int'(h_front_m1); endcase
    endfunction
    function automatic int vlen(int ph);
        case (ph) 0: return int'(v_sync_m1); 1: return int'(v_back_m1);
                  2: return int'(v_act_m1); default: return int'(v_front_m1); endcase
    endfunction
    function automatic bit exp_ce();
        return scan_en && (!div_sel || m_div >= int'(div_m1));
    endfunction

    task automatic cmp(input string req, input string sig, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", req, sig, $time, act, exp);
        end
    endtask

    // Model update on each active edge, from pre-edge state and inputs.
    always @(posedge clk) begin
        bit ce, hw, vw;
        if (!rst_n) begin
            m_div = 0; m_hph = 0; m_hcnt = 0; m_vph = 0; m_vcnt = 0; m_pend = 0;
        end else begin
            ce = exp_ce();
            hw = (m_hph == 3) && (m_hcnt >= hlen(3));
            vw = (m_vph == 3) && (m_vcnt >= vlen(3));
            if (ce && hw && vw && irq_master_en && irq_frame_en) m_pend = 1;
            else if (irq_ack) m_pend = 0;
            if (!scan_en) begin
                m_div = 0; m_hph = 0; m_hcnt = 0; m_vph = 0; m_vcnt = 0;
            end else begin
                m_div = (!div_sel || m_div >= int'(div_m1)) ? 0 : m_div + 1;
                if (ce) begin
                    if (ce && hw) begin
                        if (m_vcnt >= vlen(m_vph)) begin m_vph = (m_vph + 1) % 4; m_vcnt = 0; end
                        else m_vcnt++;
                    end
                    if (m_hcnt >= hlen(m_hph)) begin m_hph = (m_hph + 1) % 4; m_hcnt = 0; end
                    else m_hcnt++;
                end
            end
        end
    end

    // Per-cycle comparison away from the edge.
    always @(negedge clk) begin
        bit hsa, vsa;
        if (started && rst_n) begin
            hsa = scan_en && m_hph == 0;
            vsa = scan_en && m_vph == 0;
            cmp(div_sel ? "R3" : "R2", "pix_ce", pix_ce, exp_ce());
            cmp("R4/R7", "hsync", hsync, hs_pol ? hsa : !hsa);
            cmp("R5/R7", "vsync", vsync, vs_pol ? vsa : !vsa);
            cmp("R6", "de", de, scan_en && m_hph == 2 && m_vph == 2);
            cmp("R8", "irq_pending", irq_pending, m_pend);
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    initial begin
        #(20 * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        cycles(3);
        @(negedge clk);
        // R1: reset state with scan disabled
        cmp("R1", "de", de, 1'b0);
        cmp("R1", "pix_ce", pix_ce, 1'b0);
        cmp("R1", "irq_pending", irq_pending, 1'b0);
        cmp("R1", "hsync", hsync, 1'b0);
        cmp("R1", "vsync", vsync, 1'b0);
        @(posedge clk); #1;
        rst_n = 1'b1; started = 1;
        // R2, R4, R5, R6, R8: 1:1 rate, interrupts enabled
        scan_en = 1'b1; irq_master_en = 1'b1; irq_frame_en = 1'b1;
        cycles(130);
        // R9: acknowledge clears the pending flag
        irq_ack = 1'b1; cycles(1); irq_ack = 1'b0;
        @(negedge clk);
        cmp("R9", "irq_pending", irq_pending, 1'b0);
        cycles(1);
        // R7: active-low syncs
        hs_pol = 1'b0; vs_pol = 1'b0;
        cycles(120);
        // R9: hold ack high across a frame start so the set wins
        irq_ack = 1'b1; cycles(70); irq_ack = 1'b0;
        // R3: divide by three
        div_sel = 1'b1; div_m1 = 8'd2;
        cycles(400);
        // R8: frame enable off, flag must stay clear after ack
        irq_ack = 1'b1; cycles(1); irq_ack = 1'b0;
        irq_frame_en = 1'b0;
        cycles(200);
        irq_frame_en = 1'b1; irq_master_en = 1'b0;
        cycles(200);
        irq_master_en = 1'b1;
        // R10: halt mid-frame
        scan_en = 1'b0;
        cycles(5);
        @(negedge clk);
        cmp("R10", "hsync", hsync, ~hs_pol);
        cmp("R10", "de", de, 1'b0);
        cmp("R10", "pix_ce", pix_ce, 1'b0);
        cycles(1);
        // R10: restart begins with both syncs active
        scan_en = 1'b1;
        @(negedge clk);
        cmp("R10", "hsync", hsync, hs_pol);
        cmp("R10", "vsync", vsync, vs_pol);
        cycles(1);
        // R3: divider field zero with divide selected
        div_m1 = 8'd0;
        cycles(100);
        // R4, R5: different geometry at 1:1
        div_sel = 1'b0; h_act_m1 = 12'd5; v_back_m1 = 12'd1; v_front_m1 = 12'd1;
        cycles(300);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule